// File: doc/BRIEF.md
# SMBus Configuration Register Target

This block is the serial configuration port of a clock fan-out buffer. It answers one fixed bus address and keeps six 8-bit configuration registers whose fields steer the rest of the buffer: float-or-drive choices for the power-down and stop conditions, loop bandwidth, bypass and half-rate selects, an eight-bit output enable mask and an eight-bit stop-eligibility mask. A host reaches the registers one at a time, by offset, or as a block that always begins at register 0.

Both bus lines are oversampled by the system clock through synchronizers. Bits are taken on the rising edge of SCL and committed on the following falling edge, so a start or stop, which happens while SCL is high, never turns into a data bit. The target pulls SDA low only through `sda_oe`. It never drives SDA high and never holds SCL low.

The controller is a single state machine. `S_IDLE` waits for a start. A start condition moves to `S_ADDR`, which collects the address byte. On a match it goes to `S_ACK_ADDR`, otherwise to `S_IGNORE`. After the acknowledge, a write goes to `S_CMD` and a read goes to `S_RD_BYTE`. `S_CMD` is followed by `S_ACK_CMD`, which leads to `S_WR_COUNT` for a block command or to `S_WR_DATA` for a byte command. `S_WR_COUNT` is followed by `S_ACK_COUNT` and then `S_WR_DATA`. Each data byte goes through `S_ACK_DATA` and then returns to `S_WR_DATA`. `S_RD_BYTE` is followed by `S_RD_ACK`. A host acknowledge there returns to `S_RD_BYTE` with the next byte, and a host not-acknowledge moves to `S_IGNORE`.

Any stop condition returns the machine to `S_IDLE`. A start on a byte boundary goes to `S_ADDR`; this is how a repeated start works. A start in the middle of a byte goes to `S_IDLE`.

Top module: `smbreg_target`

## Requirements
- R1: The target acknowledges an address byte of 0xDC (write) or 0xDD (read), that is, 7-bit address 0x6E followed by the direction bit. It does not acknowledge any other address byte and ignores the rest of that transfer.
- R2: A byte write uses a command byte with bit 7 = 1, and command bits 6:0 select the register offset. The target acknowledges the data byte and stores it in the selected register.
- R3: A byte read uses a command byte with bit 7 = 1 that sets the offset, then a repeated start and the read address. The target returns the register at that offset.
- R4: A block write uses command 0x00, followed by a byte count that is acknowledged and not used. The data bytes that follow fill registers 0, 1, 2 and so on in order, and each one is acknowledged. A stop after any complete byte keeps the bytes already written and leaves the later registers unchanged.
- R5: A block read uses command 0x00, a repeated start and the read address. The target first returns the count 6, then registers 0 upward, for as long as the host acknowledges. Every byte is sent most significant bit first.
- R6: After reset the registers hold 0x07, 0xFF, 0x00, 0x00, 0x08 and 0x00, in offset order 0 to 5.
- R7: Register 4 is read-only and always reads 0x08: revision 0 in bits 7:4 and vendor code 8 in bits 3:0. Bits 5:3 of register 0 and all bits of registers 3 and 5 are reserved and always read 0.
- R8: Writes to offsets 6 and above are acknowledged and discarded. Reads from those offsets return 0x00.
- R9: A stop in the middle of a byte ends the transfer and writes nothing. A start in the middle of a byte also ends the transfer, and the target then ignores the bus until the next start.
- R10: The control outputs map to register 0 as follows: `pwrdn_float` is bit 7, `halt_float` is bit 6, `low_bw` is bit 2, `pll_mode` is bit 1 and `full_rate` is bit 0. `out_enable` is register 1 and `stop_mask` is register 2.
- R11: `sda_oe` rises only while the synchronized SCL is low. It is 0 whenever the machine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| pwrdn_float | output | 1 | Float outputs during power-down (register 0 bit 7) |
| halt_float | output | 1 | Float stopped outputs (register 0 bit 6) |
| low_bw | output | 1 | Low loop bandwidth select (register 0 bit 2) |
| pll_mode | output | 1 | 1 selects loop mode, 0 selects bypass (register 0 bit 1) |
| full_rate | output | 1 | 1 selects full rate, 0 selects half rate (register 0 bit 0) |
| out_enable | output | 8 | Per-output enable mask (register 1) |
| stop_mask | output | 8 | Per-output stop-eligibility mask (register 2) |

## Verification
The assertions assume a well-behaved host. Each SCL phase lasts several system clocks, longer than the synchronizer depth plus the edge register. SDA changes only while SCL is low, except when the host creates a start or stop. The host never creates a start or stop while the target is pulling SDA low. The bench drives both lines at the falling clock edge and holds every quarter bit period for ten system clocks. It changes data only after SCL has been low for a quarter period and releases SDA whenever the target is due to answer. The abort cases break a byte only at points where SCL is low and the target is not driving.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam int REG_W = 8;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ACK_ADDR,
        S_CMD,
        S_ACK_CMD,
        S_WR_COUNT,
        S_ACK_COUNT,
        S_WR_DATA,
        S_ACK_DATA,
        S_RD_BYTE,
        S_RD_ACK,
        S_IGNORE
    } fsm_state_t;

    // Power-up contents per offset
    function automatic logic [REG_W-1:0] reg_default(input int idx);
        case (idx)
            0:       reg_default = 8'h07;
            1:       reg_default = 8'hFF;
            4:       reg_default = 8'h08;
            default: reg_default = 8'h00;
        endcase
    endfunction

    // Bits a host may change per offset (reserved and read-only bits are 0)
    function automatic logic [REG_W-1:0] reg_wmask(input int idx);
        case (idx)
            0:       reg_wmask = 8'hC7;
            1, 2:    reg_wmask = 8'hFF;
            default: reg_wmask = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smbreg_sync.sv
module smbreg_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{RESET_VAL}};
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
    import smbreg_pkg::*;
#(
    parameter int NUM_REGS = 6,
    parameter int IDX_W    = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    logic [REG_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= reg_default(g);
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs[g] <= (wr_data & reg_wmask(g)) | (reg_default(g) & ~reg_wmask(g));
        end
        assign regs_flat[g*REG_W +: REG_W] = regs[g];
    end

    // Offsets past the last register read as zero
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/smbreg_fsm.sv
module smbreg_fsm
    import smbreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6E,
    parameter int         NUM_REGS = 6,
    parameter int         IDX_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_q,
    input  logic             sda_q,
    input  logic [REG_W-1:0] rd_data,
    output logic [IDX_W-1:0] ptr,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_data,
    output logic             sda_oe,
    output logic             idle
);
    localparam logic [REG_W-1:0] BLK_COUNT = REG_W'(NUM_REGS);
    localparam logic [IDX_W-1:0] PTR_MAX   = {IDX_W{1'b1}};

    fsm_state_t       state, state_n;
    logic [2:0]       bitcnt, bitcnt_n;
    logic [REG_W-1:0] shreg, shreg_n, tx, tx_n;
    logic [IDX_W-1:0] ptr_n;
    logic             bit_hold, bit_hold_n, bit_valid, bit_valid_n;
    logic             is_read, is_read_n, cnt_pend, cnt_pend_n, sda_oe_n;
    logic             scl_prev, sda_prev;
    logic             rise_ev, fall_ev, start_ev, stop_ev;
    logic [REG_W-1:0] byte_in;
    logic [IDX_W-1:0] ptr_inc;

    assign rise_ev  =  scl_q & ~scl_prev;
    assign fall_ev  = ~scl_q &  scl_prev;
    assign start_ev =  scl_q &  scl_prev &  sda_prev & ~sda_q;
    assign stop_ev  =  scl_q &  scl_prev & ~sda_prev &  sda_q;
    assign byte_in  = {shreg[REG_W-2:0], bit_hold};
    assign ptr_inc  = (ptr == PTR_MAX) ? ptr : ptr + 1'b1;

    // State and datapath register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= '0;
            ptr       <= '0;
            bit_hold  <= 1'b1;
            bit_valid <= 1'b0;
            is_read   <= 1'b0;
            cnt_pend  <= 1'b0;
            sda_oe    <= 1'b0;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            state     <= state_n;
            bitcnt    <= bitcnt_n;
            shreg     <= shreg_n;
            tx        <= tx_n;
            ptr       <= ptr_n;
            bit_hold  <= bit_hold_n;
            bit_valid <= bit_valid_n;
            is_read   <= is_read_n;
            cnt_pend  <= cnt_pend_n;
            sda_oe    <= sda_oe_n;
            scl_prev  <= scl_q;
            sda_prev  <= sda_q;
        end
    end

    // Next-state and output decode
    always_comb begin
        state_n     = state;
        bitcnt_n    = bitcnt;
        shreg_n     = shreg;
        tx_n        = tx;
        ptr_n       = ptr;
        bit_hold_n  = bit_hold;
        bit_valid_n = bit_valid;
        is_read_n   = is_read;
        cnt_pend_n  = cnt_pend;
        sda_oe_n    = sda_oe;
        wr_en       = 1'b0;
        wr_data     = byte_in;

        if (stop_ev) begin
            state_n     = S_IDLE;
            bitcnt_n    = '0;
            bit_valid_n = 1'b0;
            sda_oe_n    = 1'b0;
        end else if (start_ev) begin
            bit_valid_n = 1'b0;
            sda_oe_n    = 1'b0;
            state_n     = (bitcnt == 3'd0) ? S_ADDR : S_IDLE;
            bitcnt_n    = '0;
        end else if (rise_ev) begin
            bit_hold_n  = sda_q;
            bit_valid_n = 1'b1;
        end else if (fall_ev && bit_valid) begin
            bit_valid_n = 1'b0;
            unique case (state)
                S_IDLE, S_IGNORE: begin
                end
                S_ADDR, S_CMD, S_WR_COUNT, S_WR_DATA: begin
                    shreg_n = byte_in;
                    if (bitcnt != 3'd7) begin
                        bitcnt_n = bitcnt + 3'd1;
                    end else begin
                        bitcnt_n = '0;
                        sda_oe_n = 1'b1;
                        unique case (state)
                            S_ADDR: begin
                                if (byte_in[7:1] == DEV_ADDR) begin
                                    is_read_n = byte_in[0];
                                    state_n   = S_ACK_ADDR;
                                end else begin
                                    sda_oe_n  = 1'b0;
                                    state_n   = S_IGNORE;
                                end
                            end
                            S_CMD: begin
                                cnt_pend_n = ~byte_in[7];
                                ptr_n      = byte_in[7] ? byte_in[IDX_W-1:0] : '0;
                                state_n    = S_ACK_CMD;
                            end
                            S_WR_COUNT: state_n = S_ACK_COUNT;
                            default: begin
                                wr_en   = 1'b1;
                                ptr_n   = ptr_inc;
                                state_n = S_ACK_DATA;
                            end
                        endcase
                    end
                end
                S_ACK_ADDR: begin
                    if (is_read) begin
                        if (cnt_pend) begin
                            tx_n       = BLK_COUNT;
                            cnt_pend_n = 1'b0;
                        end else begin
                            tx_n  = rd_data;
                            ptr_n = ptr_inc;
                        end
                        sda_oe_n = ~tx_n[7];
                        state_n  = S_RD_BYTE;
                    end else begin
                        sda_oe_n = 1'b0;
                        state_n  = S_CMD;
                    end
                end
                S_ACK_CMD: begin
                    sda_oe_n = 1'b0;
                    state_n  = cnt_pend ? S_WR_COUNT : S_WR_DATA;
                end
                S_ACK_COUNT, S_ACK_DATA: begin
                    sda_oe_n = 1'b0;
                    state_n  = S_WR_DATA;
                end
                S_RD_BYTE: begin
                    if (bitcnt == 3'd7) begin
                        bitcnt_n = '0;
                        sda_oe_n = 1'b0;
                        state_n  = S_RD_ACK;
                    end else begin
                        bitcnt_n = bitcnt + 3'd1;
                        tx_n     = tx << 1;
                        sda_oe_n = ~tx[6];
                    end
                end
                S_RD_ACK: begin
                    if (!bit_hold) begin
                        tx_n     = rd_data;
                        ptr_n    = ptr_inc;
                        sda_oe_n = ~rd_data[7];
                        state_n  = S_RD_BYTE;
                    end else begin
                        state_n  = S_IGNORE;
                    end
                end
            endcase
        end
    end

    assign idle = (state == S_IDLE);
endmodule

// File: rtl/smbreg_target.sv
module smbreg_target
    import smbreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6E,
    parameter int         NUM_REGS    = 6,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       pwrdn_float,
    output logic       halt_float,
    output logic       low_bw,
    output logic       pll_mode,
    output logic       full_rate,
    output logic [7:0] out_enable,
    output logic [7:0] stop_mask
);
    localparam int IDX_W = 7;

    logic                      scl_q, sda_q, wr_en, fsm_idle;
    logic [IDX_W-1:0]          ptr;
    logic [REG_W-1:0]          wr_data, rd_data;
    logic [NUM_REGS*REG_W-1:0] regs_flat;

    smbreg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_q)
    );
    smbreg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_q)
    );

    smbreg_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
        .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
        .sda_oe(sda_oe), .idle(fsm_idle)
    );

    smbreg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(ptr),
        .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_data),
        .regs_flat(regs_flat)
    );

    assign pwrdn_float = regs_flat[7];
    assign halt_float  = regs_flat[6];
    assign low_bw      = regs_flat[2];
    assign pll_mode    = regs_flat[1];
    assign full_rate   = regs_flat[0];
    assign out_enable  = regs_flat[15:8];
    assign stop_mask   = regs_flat[23:16];
endmodule

// File: rtl/smbreg_checker.sv
module smbreg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_q,
    input logic       sda_oe,
    input logic       in_idle,
    input logic       wr_en,
    input logic [7:0] out_enable,
    input logic [7:0] stop_mask
);
    a_r6_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_enable == 8'hFF && stop_mask == 8'h00));

    a_r11_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_q);

    a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_oe);

    a_r2_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(out_enable) && $stable(stop_mask)) |-> $past(wr_en));

    a_r8_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> sda_oe);
endmodule

bind smbreg_target smbreg_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
    .in_idle(fsm_idle), .wr_en(wr_en),
    .out_enable(out_enable), .stop_mask(stop_mask)
);

// File: tb/smbreg_target_test.sv
module smbreg_target_test;
    localparam int QTR = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       sda_oe, pwrdn_float, halt_float, low_bw, pll_mode, full_rate;
    logic [7:0] out_enable, stop_mask;
    logic       sda_line;
    int         checks = 0;
    int         errs = 0;
    bit         done = 1'b0;

    assign sda_line = sda_h & ~sda_oe;

    always #2 clk = ~clk;

    smbreg_target uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
        .sda_oe(sda_oe), .pwrdn_float(pwrdn_float), .halt_float(halt_float),
        .low_bw(low_bw), .pll_mode(pll_mode), .full_rate(full_rate),
        .out_enable(out_enable), .stop_mask(stop_mask)
    );

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; w(QTR);
        scl_h = 1'b1; w(QTR);
        sda_h = 1'b0; w(QTR);
        scl_h = 1'b0; w(QTR);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; w(QTR);
        scl_h = 1'b1; w(QTR);
        sda_h = 1'b1; w(2*QTR);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_h = b[i]; w(QTR);
            scl_h = 1'b1; w(2*QTR);
            scl_h = 1'b0; w(QTR);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_h = 1'b1; w(QTR);
        scl_h = 1'b1; w(QTR);
        acked = ~sda_line; w(QTR);
        scl_h = 1'b0; w(QTR);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_h = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            w(QTR); scl_h = 1'b1;
            w(QTR); b[i] = sda_line;
            w(QTR); scl_h = 1'b0;
            w(QTR);
        end
        sda_h = nack; w(QTR);
        scl_h = 1'b1; w(2*QTR);
        scl_h = 1'b0; w(QTR);
        sda_h = 1'b1;
    endtask

    task automatic byte_write(input string req, input logic [6:0] off, input logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hDC, a);         chk({req, " addr ack"}, {7'd0, a}, 8'h01);
        send_byte({1'b1, off}, a);   chk({req, " cmd ack"}, {7'd0, a}, 8'h01);
        send_byte(d, a);             chk({req, " data ack"}, {7'd0, a}, 8'h01);
        bus_stop();
    endtask

    task automatic byte_read(input string req, input logic [6:0] off, input logic [7:0] exp);
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hDC, a);
        send_byte({1'b1, off}, a);
        bus_start();
        send_byte(8'hDD, a);         chk({req, " read addr ack"}, {7'd0, a}, 8'h01);
        recv_byte(1'b1, d);          chk({req, " read data"}, d, exp);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R6 out_enable reset", out_enable, 8'hFF);
        chk("R6 stop_mask reset", stop_mask, 8'h00);
        chk("R10 ctrl bits reset",
            {3'd0, pwrdn_float, halt_float, low_bw, pll_mode, full_rate}, 8'h07);
        chk("R11 released at reset", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_block_read(input string req, input logic [7:0] e0, input logic [7:0] e1,
                                input logic [7:0] e2);
        logic a;
        logic [7:0] d;
        logic [7:0] exp [7];
        exp = '{8'h06, e0, e1, e2, 8'h00, 8'h08, 8'h00};
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h00, a);         chk({req, " cmd ack"}, {7'd0, a}, 8'h01);
        bus_start();
        send_byte(8'hDD, a);         chk({req, " R1 read addr ack"}, {7'd0, a}, 8'h01);
        for (int i = 0; i < 7; i++) begin
            recv_byte(i == 6, d);
            chk($sformatf("%s byte %0d (R5 R7)", req, i), d, exp[i]);
        end
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start();
        send_byte(8'hD0, a);         chk("R1 foreign addr nack", {7'd0, a}, 8'h00);
        send_byte(8'h81, a);         chk("R1 ignored cmd nack", {7'd0, a}, 8'h00);
        send_byte(8'h00, a);
        bus_stop();
        chk("R1 out_enable untouched", out_enable, 8'h5A);
    endtask

    task automatic t_block_write();
        logic a;
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h00, a);         chk("R4 cmd ack", {7'd0, a}, 8'h01);
        send_byte(8'h03, a);         chk("R4 count ack", {7'd0, a}, 8'h01);
        send_byte(8'hC2, a);         chk("R4 data0 ack", {7'd0, a}, 8'h01);
        send_byte(8'hA5, a);         chk("R4 data1 ack", {7'd0, a}, 8'h01);
        send_byte(8'h3C, a);         chk("R4 data2 ack", {7'd0, a}, 8'h01);
        bus_stop();
        chk("R10 ctrl bits after block",
            {3'd0, pwrdn_float, halt_float, low_bw, pll_mode, full_rate}, 8'h1A);
        chk("R4 out_enable", out_enable, 8'hA5);
        chk("R4 stop_mask", stop_mask, 8'h3C);
    endtask

    task automatic t_block_partial();
        logic a;
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h00, a);
        send_byte(8'h06, a);
        send_byte(8'hFF, a);         chk("R4 partial data0 ack", {7'd0, a}, 8'h01);
        bus_stop();
        byte_read("R4 partial reg0 (R7 reserved)", 7'd0, 8'hC7);
        chk("R4 partial out_enable kept", out_enable, 8'hA5);
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h82, a);
        send_bits(8'h00, 4);
        bus_stop();
        chk("R9 stop mid-byte no write", stop_mask, 8'h3C);
        bus_start();
        send_byte(8'hDC, a);
        send_byte(8'h82, a);
        send_bits(8'h00, 4);
        bus_start();
        send_byte(8'hDC, a);         chk("R9 ignored after mid-byte start", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R9 stop_mask still kept", stop_mask, 8'h3C);
        byte_write("R9 recover", 7'd2, 8'h81);
        chk("R9 recovered write", stop_mask, 8'h81);
    endtask

    initial begin
        w(5);
        rst_n = 1'b1;
        w(5);
        t_reset();
        t_block_read("R5 reset block read", 8'h07, 8'hFF, 8'h00);
        byte_write("R2", 7'd1, 8'h5A);
        chk("R2 out_enable", out_enable, 8'h5A);
        byte_read("R3", 7'd1, 8'h5A);
        t_wrong_addr();
        t_block_write();
        t_block_read("R5 block read after write", 8'hC2, 8'hA5, 8'h3C);
        t_block_partial();
        byte_write("R7 ro", 7'd4, 8'hFF);
        byte_read("R7 vendor", 7'd4, 8'h08);
        byte_write("R7 rsv", 7'd3, 8'hFF);
        byte_read("R7 reserved reg3", 7'd3, 8'h00);
        byte_write("R8", 7'd16, 8'hEE);
        byte_read("R8 high offset", 7'd16, 8'h00);
        chk("R8 out_enable kept", out_enable, 8'hA5);
        chk("R8 stop_mask kept", stop_mask, 8'h3C);
        t_abort();
        chk("R11 released at end", {7'd0, sda_oe}, 8'h00);
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 150000 && !done; n++) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule